// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Writes and reads are requested with active-low enables. The storage holds D = 2**AW words of DW bits each. While master reset is held, an input selects one of two read behaviours, and this choice is fixed until the next reset.

In request-driven (standard) mode, every word is taken only when the reader asks for it. In fall-through mode, the oldest word is moved on its own into an output holding register. It waits there until the reader consumes it, and that register adds one word of capacity. Each mode has its own meaning and polarity for the read-side and write-side status flags.

The block also drives three level flags: half-full, almost-empty and almost-full. The almost flags use two offset registers. A second input held during reset picks their defaults, and a parallel write port can change them afterwards. The pointers cross between the two clock domains as Gray code. Each flag is computed in the clock domain of the side it governs.

Top module: `dmf_fifo`

## Requirements
- R1: The read mode is captured while `mrst_n` is low: `fall_sel` low gives standard mode, high gives fall-through mode. Changes to `fall_sel` after reset has been released have no effect.
- R2: In standard mode, `rflag` is high exactly when at least one word is stored. A word is taken at a rising `rclk` edge where `ren_n` is low and `rflag` is high, and it appears on `dout` after that edge. `dout` does not change without such a read.
- R3: In standard mode, with c the number of stored words, n the empty offset and m the full offset: `aempty_n` is high when c >= n+1; `half_n` is low when c >= D/2+1; `afull_n` is low when c >= D-m; `wflag` is low when c = D.
- R4: In fall-through mode, a word written into an empty FIFO appears on `dout`, with `rflag` low, at the third rising `rclk` edge after the write edge. Before that edge `rflag` stays high, and no read request is needed.
- R5: In fall-through mode the capacity is D+1 words. `wflag` goes high, blocking writes, once D+1 words are held with no reads. `rflag` low means `dout` holds valid data. A low `ren_n` at an `rclk` edge consumes that word.
- R6: In fall-through mode, with c counting the word on `dout`: `aempty_n` is high when c >= n+2; `half_n` is low when c >= D/2+2; `afull_n` is low when c >= D+1-m.
- R7: A write request while the FIFO is full is dropped. The stored words and their order are unchanged.
- R8: A read request while no word is available is ignored. This means `rflag` low in standard mode and `rflag` high in fall-through mode. `dout` and the count stay as they are.
- R9: `dflt_sel` high during reset sets both offsets to 1023. Low sets both to 127.
- R10: When `ofs_we` is high at a rising `wclk` edge, `ofs_val` is written into the empty offset if `ofs_which` = 0, or into the full offset if `ofs_which` = 1.
- R11: Words leave in the order they were written, with their values intact, across the two clock domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| fall_sel | input | 1 | Read-mode select captured during reset (1 = fall-through) |
| dflt_sel | input | 1 | Offset default select captured during reset (1 = 1023, 0 = 127) |
| wen_n | input | 1 | Write request, active low |
| din | input | DW | Write data |
| ren_n | input | 1 | Read request, active low |
| ofs_we | input | 1 | Offset register write strobe (wclk domain) |
| ofs_which | input | 1 | Offset select: 0 = empty offset, 1 = full offset |
| ofs_val | input | AW | Offset value to write |
| dout | output | DW | Read data |
| rflag | output | 1 | Standard: high = data stored; fall-through: low = dout valid |
| wflag | output | 1 | Standard: low = full; fall-through: high = full |
| half_n | output | 1 | Low when more than half full |
| aempty_n | output | 1 | Low when almost empty |
| afull_n | output | 1 | Low when almost full |

## Verification
The assertions rely on four things holding at the inputs. Both clocks run while `mrst_n` is low, so that the mode and offset defaults are captured. `fall_sel` and `dflt_sel` are steady during reset. Offsets are below D. Offsets change only while the FIFO is idle and empty, because the read side uses the empty offset without synchronising it.

The stimulus keeps within these limits in several ways. It holds reset for several cycles of both clocks and writes offsets only straight after reset, before any data. It changes every input one nanosecond after a clock edge. It flips `fall_sel` to the opposite value once reset is released, so that a late mode change would show up in the flags.

// File: rtl/dmf_pkg.sv
`timescale 1ns/1ps
package dmf_pkg;

   // read behaviour selected at master reset
   typedef enum logic {
      RD_STD  = 1'b0,
      RD_FWFT = 1'b1
   } rd_mode_e;

   // offset defaults picked by the load-select input during reset
   localparam int unsigned DMF_OFS_WIDE   = 32'h3FF;
   localparam int unsigned DMF_OFS_NARROW = 32'h07F;

endpackage

// File: rtl/dmf_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a Gray-coded pointer.
module dmf_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dmf_mem.sv
`timescale 1ns/1ps
// Storage array: synchronous write, combinational read.
module dmf_mem #(
   parameter int unsigned DW = 9,
   parameter int unsigned AW = 11
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int unsigned WORDS = 1 << AW;

   logic [DW-1:0] arr [WORDS];

   always_ff @(posedge wclk) begin
      if (we) arr[waddr] <= wdata;
   end

   assign rdata = arr[raddr];

endmodule

// File: rtl/dmf_ofs.sv
`timescale 1ns/1ps
// Offset registers: defaults captured during reset, parallel update after.
module dmf_ofs #(
   parameter int unsigned AW     = 11,
   parameter int unsigned OFS_HI = dmf_pkg::DMF_OFS_WIDE,
   parameter int unsigned OFS_LO = dmf_pkg::DMF_OFS_NARROW
) (
   input  logic          wclk,
   input  logic          mrst_n,
   input  logic          dflt_sel,
   input  logic          we,
   input  logic          which,
   input  logic [AW-1:0] val,
   output logic [AW-1:0] ofs_empty,
   output logic [AW-1:0] ofs_full
);

   localparam logic [AW-1:0] HI_V = AW'(OFS_HI);
   localparam logic [AW-1:0] LO_V = AW'(OFS_LO);

   always_ff @(posedge wclk) begin
      if (!mrst_n) begin
         ofs_empty <= dflt_sel ? HI_V : LO_V;
         ofs_full  <= dflt_sel ? HI_V : LO_V;
      end else if (we) begin
         if (which) ofs_full  <= val;
         else       ofs_empty <= val;
      end
   end

endmodule

// File: rtl/dmf_wside.sv
`timescale 1ns/1ps
// Write domain: pointer, full, half-full and almost-full flags.
module dmf_wside #(
   parameter int unsigned AW = 11
) (
   input  logic          wclk,
   input  logic          mrst_n,
   input  logic          wen_n,
   input  logic [AW:0]   rgray_s,
   input  logic [AW-1:0] ofs_full,
   output logic          we,
   output logic [AW:0]   wbin,
   output logic [AW:0]   wgray,
   output logic          full,
   output logic          half_n,
   output logic          afull_n
);

   localparam logic [AW:0] DEPTH  = (AW+1)'(1) << AW;
   localparam logic [AW:0] HALF_T = (DEPTH >> 1) + (AW+1)'(1);

   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0] rbin_s;
   logic [AW:0] wbin_nxt;
   logic [AW:0] cnt_nxt;
   logic [AW:0] af_t;

   assign rbin_s   = g2b(rgray_s);
   assign we       = !wen_n && !full;
   assign wbin_nxt = wbin + (AW+1)'(we);
   assign cnt_nxt  = wbin_nxt - rbin_s;
   assign af_t     = DEPTH - {1'b0, ofs_full};

   always_ff @(posedge wclk or negedge mrst_n) begin
      if (!mrst_n) begin
         wbin    <= '0;
         wgray   <= '0;
         full    <= 1'b0;
         half_n  <= 1'b1;
         afull_n <= 1'b1;
      end else begin
         wbin    <= wbin_nxt;
         wgray   <= wbin_nxt ^ (wbin_nxt >> 1);
         full    <= (cnt_nxt == DEPTH);
         half_n  <= !(cnt_nxt >= HALF_T);
         afull_n <= !(cnt_nxt >= af_t);
      end
   end

endmodule

// File: rtl/dmf_rside.sv
`timescale 1ns/1ps
// Read domain: pointer, output register, data-present and almost-empty.
module dmf_rside #(
   parameter int unsigned DW = 9,
   parameter int unsigned AW = 11
) (
   input  logic             rclk,
   input  logic             mrst_n,
   input  dmf_pkg::rd_mode_e mode,
   input  logic             ren_n,
   input  logic [AW:0]      wgray_s,
   input  logic [AW-1:0]    ofs_empty,
   input  logic [DW-1:0]    mem_rdata,
   output logic [AW:0]      rbin,
   output logic [AW:0]      rgray,
   output logic [DW-1:0]    dout,
   output logic             have,
   output logic             ov,
   output logic             aempty_n
);

   import dmf_pkg::*;

   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic          fwft;
   logic [AW:0]   wbin_s;
   logic          ram_ne;
   logic          std_take;
   logic          fw_take;
   logic          load;
   logic          ov_nxt;
   logic [AW:0]   rbin_nxt;
   logic [AW:0]   rc_nxt;
   logic [AW:0]   tot_nxt;
   logic [AW:0]   ae_lim;

   assign fwft     = (mode == RD_FWFT);
   assign wbin_s   = g2b(wgray_s);
   assign ram_ne   = (rbin != wbin_s);
   assign std_take = !fwft && !ren_n && have;
   assign fw_take  = fwft && ov && !ren_n;
   // fall-through refills the output register whenever it is free or consumed
   assign load     = fwft ? (ram_ne && (!ov || fw_take)) : std_take;
   assign ov_nxt   = fwft && (load || (ov && !fw_take));
   assign rbin_nxt = rbin + (AW+1)'(load);
   assign rc_nxt   = wbin_s - rbin_nxt;
   assign tot_nxt  = rc_nxt + (AW+1)'(ov_nxt);
   assign ae_lim   = {1'b0, ofs_empty} + (AW+1)'(fwft);

   always_ff @(posedge rclk or negedge mrst_n) begin
      if (!mrst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         have     <= 1'b0;
         ov       <= 1'b0;
         aempty_n <= 1'b0;
      end else begin
         rbin     <= rbin_nxt;
         rgray    <= rbin_nxt ^ (rbin_nxt >> 1);
         have     <= (rbin_nxt != wbin_s);
         ov       <= ov_nxt;
         aempty_n <= (tot_nxt > ae_lim);
      end
   end

   always_ff @(posedge rclk or negedge mrst_n) begin
      if (!mrst_n)   dout <= '0;
      else if (load) dout <= mem_rdata;
   end

endmodule

// File: rtl/dmf_fifo.sv
`timescale 1ns/1ps
// Top: dual-clock FIFO with reset-selected read mode and programmable flags.
module dmf_fifo #(
   parameter int unsigned DW          = 9,
   parameter int unsigned AW          = 11,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OFS_HI      = dmf_pkg::DMF_OFS_WIDE,
   parameter int unsigned OFS_LO      = dmf_pkg::DMF_OFS_NARROW
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          fall_sel,
   input  logic          dflt_sel,
   input  logic          wen_n,
   input  logic [DW-1:0] din,
   input  logic          ren_n,
   input  logic          ofs_we,
   input  logic          ofs_which,
   input  logic [AW-1:0] ofs_val,
   output logic [DW-1:0] dout,
   output logic          rflag,
   output logic          wflag,
   output logic          half_n,
   output logic          aempty_n,
   output logic          afull_n
);

   import dmf_pkg::*;

   localparam int unsigned DEPTH = 1 << AW;

   // elaboration-time parameter checks
   generate
      if (AW < 2 || AW > 16) begin : g_bad_aw
         $error("dmf_fifo: AW must lie in 2..16");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dmf_fifo: DW must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dmf_fifo: SYNC_STAGES must be at least 2");
      end
      if (OFS_HI >= DEPTH || OFS_LO >= DEPTH) begin : g_bad_ofs
         $error("dmf_fifo: offset defaults must be below the depth");
      end
   endgenerate

   rd_mode_e      mode_w;
   rd_mode_e      mode_r;
   logic          we_w;
   logic [AW:0]   wbin_w;
   logic [AW:0]   wgray_w;
   logic [AW:0]   wgray_s;
   logic [AW:0]   rbin_r;
   logic [AW:0]   rgray_r;
   logic [AW:0]   rgray_s;
   logic          full_w;
   logic          have_r;
   logic          ov_r;
   logic [AW-1:0] ofs_empty;
   logic [AW-1:0] ofs_full;
   logic [DW-1:0] mem_rdata;

   // read mode captured in each domain while master reset is held
   always_ff @(posedge wclk) begin
      if (!mrst_n) mode_w <= fall_sel ? RD_FWFT : RD_STD;
   end

   always_ff @(posedge rclk) begin
      if (!mrst_n) mode_r <= fall_sel ? RD_FWFT : RD_STD;
   end

   dmf_ofs #(.AW(AW), .OFS_HI(OFS_HI), .OFS_LO(OFS_LO)) u_ofs (
      .wclk      (wclk),
      .mrst_n    (mrst_n),
      .dflt_sel  (dflt_sel),
      .we        (ofs_we),
      .which     (ofs_which),
      .val       (ofs_val),
      .ofs_empty (ofs_empty),
      .ofs_full  (ofs_full)
   );

   dmf_wside #(.AW(AW)) u_wside (
      .wclk     (wclk),
      .mrst_n   (mrst_n),
      .wen_n    (wen_n),
      .rgray_s  (rgray_s),
      .ofs_full (ofs_full),
      .we       (we_w),
      .wbin     (wbin_w),
      .wgray    (wgray_w),
      .full     (full_w),
      .half_n   (half_n),
      .afull_n  (afull_n)
   );

   dmf_mem #(.DW(DW), .AW(AW)) u_mem (
      .wclk  (wclk),
      .we    (we_w),
      .waddr (wbin_w[AW-1:0]),
      .wdata (din),
      .raddr (rbin_r[AW-1:0]),
      .rdata (mem_rdata)
   );

   dmf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk   (rclk),
      .rst_n (mrst_n),
      .d     (wgray_w),
      .q     (wgray_s)
   );

   dmf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk   (wclk),
      .rst_n (mrst_n),
      .d     (rgray_r),
      .q     (rgray_s)
   );

   dmf_rside #(.DW(DW), .AW(AW)) u_rside (
      .rclk      (rclk),
      .mrst_n    (mrst_n),
      .mode      (mode_r),
      .ren_n     (ren_n),
      .wgray_s   (wgray_s),
      .ofs_empty (ofs_empty),
      .mem_rdata (mem_rdata),
      .rbin      (rbin_r),
      .rgray     (rgray_r),
      .dout      (dout),
      .have      (have_r),
      .ov        (ov_r),
      .aempty_n  (aempty_n)
   );

   // flag polarity follows the selected mode
   assign rflag = (mode_r == RD_FWFT) ? !ov_r  : have_r;
   assign wflag = (mode_w == RD_FWFT) ? full_w : !full_w;

endmodule

// File: rtl/dmf_fifo_chk.sv
`timescale 1ns/1ps
// Property checker bound into dmf_fifo.
module dmf_fifo_chk #(
   parameter int unsigned DW = 9,
   parameter int unsigned AW = 11
) (
   input logic              wclk,
   input logic              rclk,
   input logic              mrst_n,
   input logic              wen_n,
   input logic              ren_n,
   input logic [DW-1:0]     dout,
   input logic              half_n,
   input logic              afull_n,
   input logic              full_w,
   input logic [AW:0]       wbin_w,
   input logic [AW:0]       rbin_r,
   input logic [AW:0]       wgray_s,
   input logic              have_r,
   input logic              ov_r,
   input dmf_pkg::rd_mode_e mode_r
);

   import dmf_pkg::*;

   // R7: a write request while full leaves the write pointer in place
   a_r7_no_overflow: assert property (@(posedge wclk) disable iff (!mrst_n)
      (full_w && !wen_n) |=> $stable(wbin_w));

   // R8: standard-mode read with nothing stored is ignored
   a_r8_no_underflow: assert property (@(posedge rclk) disable iff (!mrst_n)
      (mode_r == RD_STD && !have_r && !ren_n) |=> $stable(rbin_r));

   // R5: a fall-through word is held until it is consumed
   a_r5_fwft_hold: assert property (@(posedge rclk) disable iff (!mrst_n)
      (mode_r == RD_FWFT && ov_r && ren_n) |=> (ov_r && $stable(dout)));

   // R3: a full FIFO is also past half and almost full
   a_r3_full_levels: assert property (@(posedge wclk) disable iff (!mrst_n)
      full_w |-> (!half_n && !afull_n));

   // R11: synchronised write pointer moves by one Gray bit at most
   a_r11_gray_step: assert property (@(posedge rclk) disable iff (!mrst_n)
      $countones(wgray_s ^ $past(wgray_s)) <= 1);

   // R11: read pointer advances by at most one word per edge
   a_r11_rptr_step: assert property (@(posedge rclk) disable iff (!mrst_n)
      (rbin_r - $past(rbin_r)) <= (AW+1)'(1));

   // R1: read mode does not move once reset is released
   a_r1_mode_hold: assert property (@(posedge rclk) disable iff (!mrst_n)
      1'b1 |=> $stable(mode_r));

endmodule

bind dmf_fifo dmf_fifo_chk #(.DW(DW), .AW(AW)) i_chk (
   .wclk    (wclk),
   .rclk    (rclk),
   .mrst_n  (mrst_n),
   .wen_n   (wen_n),
   .ren_n   (ren_n),
   .dout    (dout),
   .half_n  (half_n),
   .afull_n (afull_n),
   .full_w  (full_w),
   .wbin_w  (wbin_w),
   .rbin_r  (rbin_r),
   .wgray_s (wgray_s),
   .have_r  (have_r),
   .ov_r    (ov_r),
   .mode_r  (mode_r)
);

// File: tb/test_dmf_fifo.sv
`timescale 1ns/1ps
module test_dmf_fifo;

   localparam int DW = 9;
   localparam int AW = 11;
   localparam int D  = 1 << AW;

   logic          wclk, rclk, mrst_n;
   logic          fall_sel, dflt_sel;
   logic          wen_n, ren_n;
   logic [DW-1:0] din;
   logic          ofs_we, ofs_which;
   logic [AW-1:0] ofs_val;
   logic [DW-1:0] dout;
   logic          rflag, wflag, half_n, aempty_n, afull_n;

   int            checks = 0;
   int            fails  = 0;
   int            cnt    = 0;   // reference occupancy
   int            mdl_n  = 0;   // reference empty offset
   int            mdl_m  = 0;   // reference full offset
   bit            fwft   = 0;
   bit            pend   = 0;
   bit            mon_on = 0;
   int            seq    = 0;
   logic [DW-1:0] sb [$];

   dmf_fifo #(.DW(DW), .AW(AW)) i_dmf_fifo (
      .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n),
      .fall_sel(fall_sel), .dflt_sel(dflt_sel),
      .wen_n(wen_n), .din(din), .ren_n(ren_n),
      .ofs_we(ofs_we), .ofs_which(ofs_which), .ofs_val(ofs_val),
      .dout(dout), .rflag(rflag), .wflag(wflag),
      .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
   );

   initial begin
      wclk = 0;
      forever #2.5 wclk = ~wclk;
   end

   initial begin
      rclk = 0;
      #2;
      forever #2.5 rclk = ~rclk;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h (count %0d)",
                  req, what, act, exp, cnt);
      end
   endtask

   // scoreboard monitor: compares each consumed word with the queue
   always @(negedge rclk) begin
      if (mon_on) begin
         if (fwft) begin
            if (!ren_n && !rflag) begin
               if (sb.size() == 0) chk("R11", "unexpected word", 32'(dout), 32'hFFFF_FFFF);
               else                chk("R11", "data order", 32'(dout), 32'(sb.pop_front()));
            end
         end else begin
            if (pend) begin
               if (sb.size() == 0) chk("R11", "unexpected word", 32'(dout), 32'hFFFF_FFFF);
               else                chk("R11", "data order", 32'(dout), 32'(sb.pop_front()));
            end
            pend = !ren_n && rflag;
         end
      end
   end

   task automatic settle();
      repeat (8) @(posedge wclk);
      @(negedge rclk);
   endtask

   task automatic check_flags();
      if (!fwft) begin
         chk("R2", "rflag",    32'(rflag),    32'(cnt > 0));
         chk("R3", "aempty_n", 32'(aempty_n), 32'(cnt > mdl_n));
         chk("R3", "half_n",   32'(half_n),   32'(!(cnt >= D/2 + 1)));
         chk("R3", "afull_n",  32'(afull_n),  32'(!(cnt >= D - mdl_m)));
         chk("R3", "wflag",    32'(wflag),    32'(cnt != D));
      end else begin
         chk("R5", "rflag",    32'(rflag),    32'(!(cnt > 0)));
         chk("R6", "aempty_n", 32'(aempty_n), 32'(cnt > mdl_n + 1));
         chk("R6", "half_n",   32'(half_n),   32'(!(cnt >= D/2 + 2)));
         chk("R6", "afull_n",  32'(afull_n),  32'(!(cnt >= D + 1 - mdl_m)));
         chk("R5", "wflag",    32'(wflag),    32'(cnt == D + 1));
      end
   endtask

   task automatic do_reset(input bit mode, input bit dsel);
      mon_on   = 0;
      mrst_n   = 0;
      fall_sel = mode;
      dflt_sel = dsel;
      wen_n    = 1;
      ren_n    = 1;
      ofs_we   = 0;
      repeat (5) @(posedge wclk);
      #1;
      mrst_n   = 1;
      fall_sel = !mode;   // R1: a late change must not take effect
      fwft     = mode;
      mdl_n    = dsel ? 1023 : 127;   // R9
      mdl_m    = dsel ? 1023 : 127;
      cnt      = 0;
      pend     = 0;
      sb.delete();
      mon_on   = 1;
      settle();
      check_flags();   // R1 R9 reset state
   endtask

   task automatic set_ofs(input bit which, input int v);
      @(posedge wclk);
      #1;
      ofs_we    = 1;
      ofs_which = which;
      ofs_val   = AW'(v);
      @(posedge wclk);
      #1;
      ofs_we    = 0;
      if (which) mdl_m = v;   // R10
      else       mdl_n = v;
   endtask

   task automatic do_write(input bit chk_now);
      logic [DW-1:0] d;
      int            cap;
      d   = DW'(seq * 37 + 5);
      seq++;
      cap = fwft ? D + 1 : D;
      @(posedge wclk);
      #1;
      wen_n = 0;
      din   = d;
      @(posedge wclk);
      #1;
      wen_n = 1;
      if (cnt < cap) begin   // R7: dropped when full
         sb.push_back(d);
         cnt++;
      end
      if (chk_now) begin
         settle();
         check_flags();
      end
   endtask

   task automatic do_read(input bit chk_now);
      @(posedge rclk);
      #1;
      ren_n = 0;
      @(posedge rclk);
      #1;
      ren_n = 1;
      if (cnt > 0) cnt--;   // R8: ignored when nothing available
      if (chk_now) begin
         settle();
         check_flags();
      end
   endtask

   initial begin
      logic [DW-1:0] held;
      logic [DW-1:0] w0;
      mrst_n = 0; fall_sel = 0; dflt_sel = 0;
      wen_n = 1; ren_n = 1; din = '0;
      ofs_we = 0; ofs_which = 0; ofs_val = '0;

      // S1: standard mode, wide defaults, fill past full and drain past empty
      do_reset(1'b0, 1'b1);
      for (int i = 0; i < D + 2; i++) do_write(1'b1);   // R3 R7 R9
      for (int i = 0; i < D + 1; i++) do_read(1'b1);    // R2 R8 R11

      // R8: read while empty leaves dout untouched
      held = dout;
      do_read(1'b1);
      chk("R8", "dout after empty read", 32'(dout), 32'(held));

      // S2: fall-through mode, narrow defaults, full cycle
      do_reset(1'b1, 1'b0);
      for (int i = 0; i < D + 2; i++) do_write(1'b1);   // R5 R6 R7 R9
      for (int i = 0; i < D + 2; i++) do_read(1'b1);    // R5 R8 R11

      // S3: standard mode, programmed offsets, mixed traffic
      do_reset(1'b0, 1'b0);
      set_ofs(1'b0, 5);      // R10 empty offset
      set_ofs(1'b1, D - 8);  // R10 full offset: afull at 8 words
      settle();
      check_flags();
      for (int i = 0; i < 12; i++) do_write(1'b1);
      for (int i = 0; i < 6; i++) begin
         do_read(1'b1);
         do_write(1'b1);
      end
      // R2: dout holds without a read request
      held = dout;
      repeat (10) @(posedge rclk);
      @(negedge rclk);
      chk("R2", "dout without read", 32'(dout), 32'(held));
      for (int i = 0; i < 13; i++) do_read(1'b1);

      // S4: fall-through latency and programmed offsets
      do_reset(1'b1, 1'b1);
      set_ofs(1'b0, 3);
      set_ofs(1'b1, D - 4);   // afull at D+1-(D-4) = 5 words
      settle();
      check_flags();
      w0 = DW'(9'h1A5);
      @(posedge wclk);
      #1;
      wen_n = 0;
      din   = w0;
      @(posedge wclk);        // write edge
      @(posedge rclk);        // first read edge
      #0.5;
      wen_n = 1;
      @(posedge rclk);        // second
      #0.5;
      chk("R4", "rflag before third edge", 32'(rflag), 32'(1));
      @(posedge rclk);        // third
      #0.5;
      chk("R4", "rflag at third edge", 32'(rflag), 32'(0));
      chk("R4", "dout at third edge",  32'(dout),  32'(w0));
      sb.push_back(w0);
      cnt = 1;
      settle();
      check_flags();
      for (int i = 0; i < 8; i++) do_write(1'b1);
      for (int i = 0; i < 3; i++) begin
         do_read(1'b1);
         do_write(1'b1);
      end
      for (int i = 0; i < 11; i++) do_read(1'b1);
      chk("R11", "scoreboard drained", 32'(sb.size()), 32'(0));

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge wclk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule